// File: doc/BRIEF.md
# Ultimatic Paddle Priority Adapter

This block sits between a dual-lever Morse paddle and the paddle input of an iambic keyer. It makes that keyer behave in ultimatic fashion. While only one lever is held, the matching key line is driven. While both levers are held, only the lever that closed most recently is keyed. Releasing that later lever hands the keying back to the lever still held. Element timing, speed and memories stay with the downstream keyer.

The two paddle contacts are active-low: 0 means closed and 1 means open. Each contact passes through a two-flop synchronizer. It then passes through a debounce filter, which accepts a new level only after it has been stable for `DEBOUNCE` clock cycles; `DEBOUNCE = 0` removes the filter. The filtered pair feeds a two-state machine that keeps a one-bit history of which lever closed first. The state register and both active-high key outputs are updated on the same clock edge from the same filtered sample.

The history machine has two states:
- `HIST_RIGHT_FIRST` is the reset state. It covers every history except a left lever closed while the right was open.
- `HIST_LEFT_FIRST` means the left lever closed while the right was open.

It has three transitions:
- ARM_LEFT moves `HIST_RIGHT_FIRST` to `HIST_LEFT_FIRST` when the sample shows left closed and right open.
- CLEAR moves `HIST_LEFT_FIRST` to `HIST_RIGHT_FIRST` whenever left is open.
- HOLD keeps the current state in every other case.

Top module: `ultimatic_adapter`

## Requirements
- R1: A synchronous reset clears the history to `HIST_RIGHT_FIRST` and drives both key outputs to 0.
- R2: With both paddle inputs at 1 (both levers open), both key outputs are 0.
- R3: With only the left input at 0, the outputs are key_l=1 and key_r=0. With only the right input at 0, they are key_l=0 and key_r=1.
- R4: When the left lever closes first and the right lever then closes, the outputs are key_r=1 and key_l=0.
- R5: When the right lever closes first and the left lever then closes, the outputs are key_l=1 and key_r=0.
- R6: While both levers are held, releasing the later lever returns keying to the lever still held.
- R7: If both levers are seen closed in the same filtered sample after both were open, the outputs are key_l=1 and key_r=0.
- R8: key_l and key_r are never both 1.
- R9: A paddle level change that lasts fewer than `DEBOUNCE` clock cycles at the filter input has no effect on the key outputs.
- R10: A paddle change held steady appears on the key outputs at the (`DEBOUNCE`+3)-th rising clock edge after it is applied: two synchronizer edges, `DEBOUNCE` filter edges, and one output edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| paddle_l_n | input | 1 | Left lever contact, 0 = closed |
| paddle_r_n | input | 1 | Right lever contact, 0 = closed |
| key_l | output | 1 | Left key-line drive, 1 = asserted |
| key_r | output | 1 | Right key-line drive, 1 = asserted |

## Verification
The state-machine assertions read the filtered levels, not the raw pins. They take for granted that those levels change only between samples and never hold X after reset, because the synchronizer and filter registers both reset to the open level. The debounce assertion assumes that a filtered level can change only after the filter input has differed from it. The stimulus drives the paddle pins only at falling clock edges. It holds each pattern far longer than the filter window, except in the deliberate short-glitch scenario, so every settled check sees a single well-defined history.

// File: rtl/ultimatic_pkg.sv
package ultimatic_pkg;

    // One-bit history of which lever closed first.
    typedef enum logic {
        HIST_RIGHT_FIRST = 1'b0,
        HIST_LEFT_FIRST  = 1'b1
    } hist_e;

    // Electrical level of an open (released) contact.
    localparam logic LEVER_OPEN = 1'b1;

endpackage

// File: rtl/ultimatic_sync.sv
module ultimatic_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    import ultimatic_pkg::*;

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{LEVER_OPEN}};
        end else begin
            chain <= {chain[STAGES-2:0], din};
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/ultimatic_debounce.sv
module ultimatic_debounce #(
    parameter int HOLD_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic clean
);
    import ultimatic_pkg::*;

    localparam int CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;

    generate
        if (HOLD_CYCLES == 0) begin : g_bypass
            assign clean = raw;
        end else begin : g_filter
            logic [CW-1:0] run_len;
            logic          level_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    level_q <= LEVER_OPEN;
                    run_len <= '0;
                end else if (raw != level_q) begin
                    if (run_len == CW'(HOLD_CYCLES - 1)) begin
                        level_q <= raw;
                        run_len <= '0;
                    end else begin
                        run_len <= run_len + 1'b1;
                    end
                end else begin
                    run_len <= '0;
                end
            end

            assign clean = level_q;

            // R9: an accepted level change needs the input to have differed
            assert_change_needs_diff_R9: assert property (
                @(posedge clk) disable iff (rst)
                (level_q != $past(level_q)) |-> ($past(raw) != $past(level_q))
            );
        end
    endgenerate

endmodule

// File: rtl/ultimatic_fsm.sv
module ultimatic_fsm (
    input  logic clk,
    input  logic rst,
    input  logic lev_l_n,
    input  logic lev_r_n,
    output logic key_l,
    output logic key_r
);
    import ultimatic_pkg::*;

    hist_e state, state_nx;

    // Next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            HIST_RIGHT_FIRST: if (!lev_l_n && lev_r_n) state_nx = HIST_LEFT_FIRST; // ARM_LEFT
            HIST_LEFT_FIRST:  if (lev_l_n)             state_nx = HIST_RIGHT_FIRST; // CLEAR
            default:          state_nx = HIST_RIGHT_FIRST;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= HIST_RIGHT_FIRST;
        else     state <= state_nx;
    end

    // Registered outputs from the same sample and the current history
    always_ff @(posedge clk) begin
        if (rst) begin
            key_l <= 1'b0;
            key_r <= 1'b0;
        end else begin
            unique case (state)
                HIST_RIGHT_FIRST: begin
                    key_l <= !lev_l_n;
                    key_r <= !lev_r_n && lev_l_n;
                end
                HIST_LEFT_FIRST: begin
                    key_l <= !lev_l_n && lev_r_n;
                    key_r <= !lev_r_n;
                end
                default: begin
                    key_l <= 1'b0;
                    key_r <= 1'b0;
                end
            endcase
        end
    end

    assert_keys_exclusive_R8: assert property (
        @(posedge clk) disable iff (rst) !(key_l && key_r)
    );

    assert_idle_quiet_R2: assert property (
        @(posedge clk) disable iff (rst)
        (lev_l_n && lev_r_n) |=> (!key_l && !key_r)
    );

    assert_left_alone_R3: assert property (
        @(posedge clk) disable iff (rst)
        (!lev_l_n && lev_r_n) |=> (key_l && !key_r)
    );

    assert_right_alone_R3: assert property (
        @(posedge clk) disable iff (rst)
        (lev_l_n && !lev_r_n) |=> (!key_l && key_r)
    );

    assert_both_after_left_R4: assert property (
        @(posedge clk) disable iff (rst)
        (!lev_l_n && !lev_r_n && state == HIST_LEFT_FIRST) |=> (key_r && !key_l)
    );

    assert_both_after_right_R5: assert property (
        @(posedge clk) disable iff (rst)
        (!lev_l_n && !lev_r_n && state == HIST_RIGHT_FIRST) |=> (key_l && !key_r)
    );

    assert_simultaneous_left_R7: assert property (
        @(posedge clk) disable iff (rst)
        (!lev_l_n && !lev_r_n && $past(lev_l_n && lev_r_n)) |=> key_l
    );

endmodule

// File: rtl/ultimatic_adapter.sv
module ultimatic_adapter #(
    parameter int SYNC_STAGES = 2,
    parameter int DEBOUNCE    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic paddle_l_n,
    input  logic paddle_r_n,
    output logic key_l,
    output logic key_r
);
    localparam int LEVERS = 2;

    logic [LEVERS-1:0] pin_n, synced_n, filt_n;

    assign pin_n = {paddle_r_n, paddle_l_n};

    generate
        for (genvar i = 0; i < LEVERS; i++) begin : g_lever
            ultimatic_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk  (clk),
                .rst  (rst),
                .din  (pin_n[i]),
                .dout (synced_n[i])
            );
            ultimatic_debounce #(.HOLD_CYCLES(DEBOUNCE)) u_deb (
                .clk   (clk),
                .rst   (rst),
                .raw   (synced_n[i]),
                .clean (filt_n[i])
            );
        end
    endgenerate

    ultimatic_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .lev_l_n (filt_n[0]),
        .lev_r_n (filt_n[1]),
        .key_l   (key_l),
        .key_r   (key_r)
    );

endmodule

// File: tb/tb_ultimatic_adapter.sv
`timescale 1ns/1ps
module tb_ultimatic_adapter;

    localparam int DEB    = 4;
    localparam int SETTLE = DEB + 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pl_n = 1'b1;
    logic pr_n = 1'b1;
    logic key_l, key_r;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    ultimatic_adapter #(.SYNC_STAGES(2), .DEBOUNCE(DEB)) dut (
        .clk(clk), .rst(rst), .paddle_l_n(pl_n), .paddle_r_n(pr_n),
        .key_l(key_l), .key_r(key_r)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: {key_l,key_r} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic expect_keys(input string tag, input logic el, input logic er);
        check({key_l, key_r} === {el, er}, tag, {key_l, key_r}, {el, er});
    endtask

    task automatic drive(input logic l_n, input logic r_n);
        @(negedge clk);
        pl_n = l_n;
        pr_n = r_n;
    endtask

    task automatic settle();
        repeat (SETTLE) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        drive(1'b0, 1'b1);
        settle();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        expect_keys("R1 reset clears keys", 1'b0, 1'b0);
        drive(1'b1, 1'b1);
        rst = 1'b0;
        settle();
        expect_keys("R1 after reset idle", 1'b0, 1'b0);
    endtask

    task automatic t_idle();
        drive(1'b1, 1'b1);
        settle();
        expect_keys("R2 both open", 1'b0, 1'b0);
    endtask

    task automatic t_single();
        drive(1'b0, 1'b1); settle();
        expect_keys("R3 left only", 1'b1, 1'b0);
        drive(1'b1, 1'b1); settle();
        drive(1'b1, 1'b0); settle();
        expect_keys("R3 right only", 1'b0, 1'b1);
        drive(1'b1, 1'b1); settle();
    endtask

    task automatic t_left_then_right();
        drive(1'b0, 1'b1); settle();
        drive(1'b0, 1'b0); settle();
        expect_keys("R4 left first then right", 1'b0, 1'b1);
        drive(1'b0, 1'b1); settle();
        expect_keys("R6 release right returns to left", 1'b1, 1'b0);
        drive(1'b1, 1'b1); settle();
    endtask

    task automatic t_right_then_left();
        drive(1'b1, 1'b0); settle();
        drive(1'b0, 1'b0); settle();
        expect_keys("R5 right first then left", 1'b1, 1'b0);
        drive(1'b1, 1'b0); settle();
        expect_keys("R6 release left returns to right", 1'b0, 1'b1);
        drive(1'b1, 1'b1); settle();
    endtask

    task automatic t_simultaneous();
        drive(1'b1, 1'b1); settle();
        drive(1'b0, 1'b0); settle();
        expect_keys("R7 simultaneous closure", 1'b1, 1'b0);
        drive(1'b1, 1'b1); settle();
    endtask

    task automatic t_glitch();
        bit moved = 1'b0;
        drive(1'b1, 1'b1); settle();
        drive(1'b0, 1'b1);
        repeat (DEB - 2) @(negedge clk);
        pl_n = 1'b1;
        for (int i = 0; i < SETTLE + 4; i++) begin
            @(negedge clk);
            if (key_l || key_r) moved = 1'b1;
        end
        check(!moved, "R9 short glitch ignored", {moved, 1'b0}, 2'b00);
    endtask

    task automatic t_latency();
        drive(1'b1, 1'b1); settle();
        drive(1'b1, 1'b0);
        repeat (DEB + 2) @(posedge clk);
        @(negedge clk);
        expect_keys("R10 one edge before latency", 1'b0, 1'b0);
        @(posedge clk);
        @(negedge clk);
        expect_keys("R10 at latency edge", 1'b0, 1'b1);
        drive(1'b1, 1'b1); settle();
    endtask

    // Walk through pseudo-random settled patterns against a history model.
    task automatic t_walk();
        logic [4:0] lfsr = 5'h13;
        logic hist = 1'b0;          // 1 = left closed while right open
        logic ol, or_, el, er;
        bit clash = 1'b0;
        drive(1'b1, 1'b1); settle();
        ol = 1'b1; or_ = 1'b1;
        for (int k = 0; k < 40; k++) begin
            lfsr = {lfsr[3:0], lfsr[4] ^ lfsr[2]};
            // change one lever at a time
            if (lfsr[0]) ol = ~ol; else or_ = ~or_;
            el = !ol && (or_ || !hist);
            er = !or_ && (hist || ol);
            hist = !ol && (or_ || hist);
            drive(ol, or_);
            for (int c = 0; c < SETTLE; c++) begin
                @(negedge clk);
                if (key_l && key_r) clash = 1'b1;
            end
            expect_keys("R4 R5 R6 model walk", el, er);
        end
        check(!clash, "R8 keys never both set", {clash, 1'b0}, 2'b00);
        drive(1'b1, 1'b1); settle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        expect_keys("R1 keys low in reset", 1'b0, 1'b0);
        rst = 1'b0;
        t_idle();
        t_single();
        t_left_then_right();
        t_right_then_left();
        t_simultaneous();
        t_glitch();
        t_latency();
        t_walk();
        t_reset();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule